// File: doc/BRIEF.md
# Machine CSR and Timer Interrupt Unit

This unit holds the machine-mode control and status registers of a small 32-bit RISC-V core and decides when a timer interrupt is taken. A pulse on the timer line sets a sticky pending bit. When global enable, timer enable and pending are all set, the unit raises a redirect in the same cycle, pointing at the handler base held in the trap-vector register. At the clock edge that ends that cycle it saves the word-aligned PC of the interrupted instruction, records the timer cause code, stacks the global enable and clears the pending bit. An MRET strobe redirects fetch back to the saved PC and restores the stacked enable.

The pipeline uses CSRRW accesses. The read data shows the old value of the addressed register in the cycle the strobe is high, and the new value is stored at the clock edge. Only six registers exist. All other addresses read as zero and ignore writes. Either an MRET or a CSRRW can share a cycle with an interrupt entry. In both cases the interrupt wins, and the other instruction's own PC is the one saved.

Top module: `csr_irq_unit`

## Requirements
- R1: After reset all registers read zero except the trap vector (address 0x305), which reads the parameter RESET_TVEC (default 0x00000100). The redirect output is low.
- R2: A high timer input at a clock edge sets the pending bit (bit 7 of address 0x344). The bit stays set whether or not interrupts are enabled.
- R3: With the CSRRW strobe high, the read data equals the register's value before the write. The written value can be read back in the following cycle.
- R4: Writable fields: in the status register (0x300) only bit 3 (global enable) and bit 7 (stacked enable); in the enable register (0x304) only bit 7 (timer enable); in the trap vector (0x305) and saved PC (0x341) bits 31:2; in the cause register (0x342) all bits; in pending (0x344) bit 7. All other bits read zero.
- R5: A read of any other CSR address returns zero, and a write to it changes no implemented register.
- R6: An interrupt is taken only when global enable, timer enable and pending are all set. In that cycle the redirect is valid and the target is the trap vector with bits 1:0 cleared.
- R7: On entry, the saved PC takes pc_i with bits 1:0 cleared and the cause register takes 0x80000007. The stacked enable takes the old global enable, the global enable clears and the pending bit clears.
- R8: MRET with no interrupt raises the redirect with the saved PC as target. At the clock edge the global enable takes the stacked enable and the stacked enable becomes 1.
- R9: If an interrupt and an MRET fall in the same cycle, the interrupt wins: the target is the trap vector and the MRET's PC is saved.
- R10: A CSRRW in the same cycle as an interrupt entry is dropped, and the registers hold their entry values.
- R11: A timer pulse in the same cycle as a software write that clears the pending bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_irq_i | input | 1 | Timer interrupt request |
| pc_i | input | 32 | PC of the instruction in the execute stage |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSRRW source value |
| csr_we_i | input | 1 | CSRRW strobe |
| mret_i | input | 1 | MRET strobe |
| csr_rdata_o | output | 32 | Value of the addressed CSR |
| redirect_valid_o | output | 1 | Fetch redirect request |
| redirect_pc_o | output | 32 | Fetch redirect target |

## Verification
The bench targets the cycles where two events collide. An MRET landing on an interrupt cycle must still vector to the handler and save the MRET's PC; a design that favours MRET would resume the old context and lose the interrupt. A CSRRW landing on an entry cycle must be dropped, or it would overwrite the fresh cause code. A timer pulse that meets a software clear of pending must keep the request, or the tick is silently lost. The bench also checks that enabling only one of the two enables leaves the request pending with no redirect. It confirms that masked bits and unimplemented addresses read zero, because a wrong mask would surface as stray bits in the readback.

// File: rtl/csr_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the machine CSR unit.
// Assumes a 12-bit CSR address space and machine mode only.
package csr_irq_pkg;

    localparam int NUM_CSR = 6;

    // Register index used by the decoder and read mux.
    localparam int IDX_STATUS = 0;
    localparam int IDX_ENABLE = 1;
    localparam int IDX_TVEC   = 2;
    localparam int IDX_EPC    = 3;
    localparam int IDX_CAUSE  = 4;
    localparam int IDX_PEND   = 5;

    // Bit positions that software and the trap logic depend on.
    localparam int BIT_GIE  = 3;
    localparam int BIT_PGIE = 7;
    localparam int BIT_TIMER = 7;
    localparam int CODE_TIMER = 7;

    // Map a register index to its architectural CSR address.
    function automatic logic [11:0] csr_addr_of(input int idx);
        case (idx)
            IDX_STATUS: csr_addr_of = 12'h300;
            IDX_ENABLE: csr_addr_of = 12'h304;
            IDX_TVEC:   csr_addr_of = 12'h305;
            IDX_EPC:    csr_addr_of = 12'h341;
            IDX_CAUSE:  csr_addr_of = 12'h342;
            default:    csr_addr_of = 12'h344;
        endcase
    endfunction

endpackage

// File: rtl/csr_addr_decode.sv
`timescale 1ns/1ps
// Module: csr_addr_decode
// Turns a CSR address into a one-hot select over the implemented registers.
// Assumes: unimplemented addresses give an all-zero select.
module csr_addr_decode
    import csr_irq_pkg::*;
(
    input  logic [11:0]         addr_i,
    output logic [NUM_CSR-1:0]  sel_o
);

    // One comparator per implemented register.
    for (genvar g = 0; g < NUM_CSR; g++) begin : g_cmp
        assign sel_o[g] = (addr_i == csr_addr_of(g));
    end

endmodule

// File: rtl/csr_pending_reg.sv
`timescale 1ns/1ps
// Module: csr_pending_reg
// Sticky timer pending bit. A timer pulse sets it, interrupt entry
// clears it, and software may write it through CSRRW.
// Assumes: a new timer pulse outranks both clear sources in the same cycle.
module csr_pending_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic timer_i,
    input  logic take_i,
    input  logic sw_we_i,
    input  logic sw_bit_i,
    output logic pend_o
);

    // Update the pending bit in priority order: timer, entry, software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_o <= 1'b0;
        else if (timer_i)
            pend_o <= 1'b1;
        else if (take_i)
            pend_o <= 1'b0;
        else if (sw_we_i)
            pend_o <= sw_bit_i;
    end

endmodule

// File: rtl/csr_machine_regs.sv
`timescale 1ns/1ps
// Module: csr_machine_regs
// Storage for status, enable, trap vector, saved PC and cause registers,
// with interrupt entry and MRET side effects.
// Assumes: wr_en_i is already suppressed during an interrupt entry, and
// ret_i is only asserted when no entry happens in the same cycle.
module csr_machine_regs
    import csr_irq_pkg::*;
#(
    parameter int               XLEN       = 32,
    parameter logic [XLEN-1:0]  RESET_TVEC = 32'h0000_0100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [NUM_CSR-1:0]  sel_i,
    input  logic [XLEN-1:0]     wdata_i,
    input  logic                take_i,
    input  logic                ret_i,
    input  logic [XLEN-1:0]     trap_pc_i,
    output logic                gie_o,
    output logic                pgie_o,
    output logic                tie_o,
    output logic [XLEN-1:0]     tvec_o,
    output logic [XLEN-1:0]     epc_o,
    output logic [XLEN-1:0]     cause_o
);

    localparam logic [XLEN-1:0] CAUSE_TIMER =
        {1'b1, {(XLEN-1){1'b0}}} | XLEN'(CODE_TIMER);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

    logic wr_status, wr_enable, wr_tvec, wr_epc, wr_cause;

    // Gate the shared write strobe with each register's select line.
    always_comb begin
        wr_status = wr_en_i & sel_i[IDX_STATUS];
        wr_enable = wr_en_i & sel_i[IDX_ENABLE];
        wr_tvec   = wr_en_i & sel_i[IDX_TVEC];
        wr_epc    = wr_en_i & sel_i[IDX_EPC];
        wr_cause  = wr_en_i & sel_i[IDX_CAUSE];
    end

    // Global and stacked enable: entry stacks, MRET unstacks, CSRRW writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_o  <= 1'b0;
            pgie_o <= 1'b0;
        end else if (take_i) begin
            pgie_o <= gie_o;
            gie_o  <= 1'b0;
        end else if (ret_i) begin
            gie_o  <= pgie_o;
            pgie_o <= 1'b1;
        end else if (wr_status) begin
            gie_o  <= wdata_i[BIT_GIE];
            pgie_o <= wdata_i[BIT_PGIE];
        end
    end

    // Timer enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tie_o <= 1'b0;
        else if (wr_enable)
            tie_o <= wdata_i[BIT_TIMER];
    end

    // Trap vector base, direct mode only, word aligned.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tvec_o <= RESET_TVEC & ALIGN_MASK;
        else if (wr_tvec)
            tvec_o <= wdata_i & ALIGN_MASK;
    end

    // Saved PC: captured on entry, otherwise software writable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            epc_o <= '0;
        else if (take_i)
            epc_o <= trap_pc_i & ALIGN_MASK;
        else if (wr_epc)
            epc_o <= wdata_i & ALIGN_MASK;
    end

    // Cause register: timer code on entry, otherwise software writable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause_o <= '0;
        else if (take_i)
            cause_o <= CAUSE_TIMER;
        else if (wr_cause)
            cause_o <= wdata_i;
    end

endmodule

// File: rtl/csr_read_mux.sv
`timescale 1ns/1ps
// Module: csr_read_mux
// Assembles the architectural view of each register and selects the
// addressed one. Assumes a one-hot or all-zero select, so an OR-reduce
// returns zero for unimplemented addresses.
module csr_read_mux
    import csr_irq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [NUM_CSR-1:0]  sel_i,
    input  logic                gie_i,
    input  logic                pgie_i,
    input  logic                tie_i,
    input  logic                pend_i,
    input  logic [XLEN-1:0]     tvec_i,
    input  logic [XLEN-1:0]     epc_i,
    input  logic [XLEN-1:0]     cause_i,
    output logic [XLEN-1:0]     rdata_o
);

    logic [XLEN-1:0] view [NUM_CSR];

    // Build the read view of each register with unimplemented bits zero.
    always_comb begin
        view[IDX_STATUS] = '0;
        view[IDX_STATUS][BIT_GIE]  = gie_i;
        view[IDX_STATUS][BIT_PGIE] = pgie_i;
        view[IDX_ENABLE] = '0;
        view[IDX_ENABLE][BIT_TIMER] = tie_i;
        view[IDX_TVEC]  = tvec_i;
        view[IDX_EPC]   = epc_i;
        view[IDX_CAUSE] = cause_i;
        view[IDX_PEND]  = '0;
        view[IDX_PEND][BIT_TIMER] = pend_i;
    end

    // OR together the selected views.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_CSR; i++)
            if (sel_i[i])
                rdata_o = rdata_o | view[i];
    end

endmodule

// File: rtl/csr_trap_ctrl.sv
`timescale 1ns/1ps
// Module: csr_trap_ctrl
// Decides interrupt entry and MRET, and forms the fetch redirect.
// Assumes: enables and pending are registered state, so the redirect is
// valid in the cycle that follows the pending bit being set.
module csr_trap_ctrl #(
    parameter int XLEN = 32
) (
    input  logic             gie_i,
    input  logic             tie_i,
    input  logic             pend_i,
    input  logic             mret_i,
    input  logic [XLEN-1:0]  tvec_i,
    input  logic [XLEN-1:0]  epc_i,
    output logic             take_o,
    output logic             ret_o,
    output logic             redirect_valid_o,
    output logic [XLEN-1:0]  redirect_pc_o
);

    // Entry needs both enables and a pending request; entry beats MRET.
    always_comb begin
        take_o = gie_i & tie_i & pend_i;
        ret_o  = mret_i & ~take_o;
    end

    // Redirect to the handler on entry, or to the saved PC on return.
    always_comb begin
        redirect_valid_o = take_o | mret_i;
        redirect_pc_o    = take_o ? {tvec_i[XLEN-1:2], 2'b00} : epc_i;
    end

endmodule

// File: rtl/csr_irq_unit.sv
`timescale 1ns/1ps
// Module: csr_irq_unit (top)
// Machine-mode CSR file with a single timer interrupt source, CSRRW
// access and MRET return. Read data is combinational from the address;
// all state changes at the rising clock edge.
// Assumes: csr_we_i and mret_i are single-cycle strobes from decode and
// pc_i is the PC of the instruction those strobes belong to.
module csr_irq_unit
    import csr_irq_pkg::*;
#(
    parameter int               XLEN       = 32,
    parameter logic [XLEN-1:0]  RESET_TVEC = 32'h0000_0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             timer_irq_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [11:0]      csr_addr_i,
    input  logic [XLEN-1:0]  csr_wdata_i,
    input  logic             csr_we_i,
    input  logic             mret_i,
    output logic [XLEN-1:0]  csr_rdata_o,
    output logic             redirect_valid_o,
    output logic [XLEN-1:0]  redirect_pc_o
);

    logic [NUM_CSR-1:0] csr_sel;
    logic               trap_take;
    logic               trap_ret;
    logic               wr_en;
    logic               gie_q, pgie_q, tie_q, pend_q;
    logic [XLEN-1:0]    tvec_q, epc_q, cause_q;

    // An instruction flushed by interrupt entry must not commit its write.
    assign wr_en = csr_we_i & ~trap_take;

    csr_addr_decode u_dec (
        .addr_i (csr_addr_i),
        .sel_o  (csr_sel)
    );

    csr_pending_reg u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .timer_i  (timer_irq_i),
        .take_i   (trap_take),
        .sw_we_i  (wr_en & csr_sel[IDX_PEND]),
        .sw_bit_i (csr_wdata_i[BIT_TIMER]),
        .pend_o   (pend_q)
    );

    csr_machine_regs #(
        .XLEN       (XLEN),
        .RESET_TVEC (RESET_TVEC)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .sel_i     (csr_sel),
        .wdata_i   (csr_wdata_i),
        .take_i    (trap_take),
        .ret_i     (trap_ret),
        .trap_pc_i (pc_i),
        .gie_o     (gie_q),
        .pgie_o    (pgie_q),
        .tie_o     (tie_q),
        .tvec_o    (tvec_q),
        .epc_o     (epc_q),
        .cause_o   (cause_q)
    );

    csr_read_mux #(
        .XLEN (XLEN)
    ) u_rmux (
        .sel_i   (csr_sel),
        .gie_i   (gie_q),
        .pgie_i  (pgie_q),
        .tie_i   (tie_q),
        .pend_i  (pend_q),
        .tvec_i  (tvec_q),
        .epc_i   (epc_q),
        .cause_i (cause_q),
        .rdata_o (csr_rdata_o)
    );

    csr_trap_ctrl #(
        .XLEN (XLEN)
    ) u_trap (
        .gie_i            (gie_q),
        .tie_i            (tie_q),
        .pend_i           (pend_q),
        .mret_i           (mret_i),
        .tvec_i           (tvec_q),
        .epc_i            (epc_q),
        .take_o           (trap_take),
        .ret_o            (trap_ret),
        .redirect_valid_o (redirect_valid_o),
        .redirect_pc_o    (redirect_pc_o)
    );

endmodule

// File: rtl/csr_irq_unit_chk.sv
`timescale 1ns/1ps
// Module: csr_irq_unit_chk
// Protocol checks on the CSR unit, bound into every instance of the top.
module csr_irq_unit_chk #(
    parameter int XLEN = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             timer_irq_i,
    input logic [XLEN-1:0]  pc_i,
    input logic             mret_i,
    input logic             redirect_valid_o,
    input logic [XLEN-1:0]  redirect_pc_o,
    input logic             trap_take,
    input logic             gie_q,
    input logic             pgie_q,
    input logic             pend_q,
    input logic [XLEN-1:0]  epc_q,
    input logic [XLEN-1:0]  cause_q
);

    // R2: a timer pulse always leaves pending set.
    assert_timer_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        timer_irq_i |=> pend_q);

    // R6: a handler redirect never happens without a pending request.
    assert_pending_needed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid_o && !mret_i) |-> pend_q);

    // R6: the handler target is word aligned.
    assert_vector_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |-> (redirect_pc_o[1:0] == 2'b00));

    // R7: entry saves the aligned PC and the timer cause.
    assert_entry_saves_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> (epc_q == {$past(pc_i[XLEN-1:2]), 2'b00})
                   && (cause_q == ({1'b1, {(XLEN-1){1'b0}}} | XLEN'(7))));

    // R7: entry masks interrupts and stacks the old enable.
    assert_entry_masks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> !gie_q && pgie_q && !$past(pend_q && 1'b0));

    // R8: MRET without entry redirects to the saved PC.
    assert_mret_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_i && !trap_take) |-> (redirect_valid_o && redirect_pc_o == epc_q));

    // R8: MRET restores the enable from the stacked copy.
    assert_mret_restore_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_i && !trap_take) |=> (gie_q == $past(pgie_q)) && pgie_q);

endmodule

bind csr_irq_unit csr_irq_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .timer_irq_i      (timer_irq_i),
    .pc_i             (pc_i),
    .mret_i           (mret_i),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o),
    .trap_take        (trap_take),
    .gie_q            (gie_q),
    .pgie_q           (pgie_q),
    .pend_q           (pend_q),
    .epc_q            (epc_q),
    .cause_q          (cause_q)
);

// File: tb/tb_csr_irq_unit.sv
`timescale 1ns/1ps
// Directed bench for csr_irq_unit. Inputs change at the falling edge,
// outputs are sampled 1 ns later, and strobes drop 1 ns after the rising edge.
module tb_csr_irq_unit;

    localparam logic [11:0] A_STATUS = 12'h300;
    localparam logic [11:0] A_ENABLE = 12'h304;
    localparam logic [11:0] A_TVEC   = 12'h305;
    localparam logic [11:0] A_EPC    = 12'h341;
    localparam logic [11:0] A_CAUSE  = 12'h342;
    localparam logic [11:0] A_PEND   = 12'h344;
    localparam logic [11:0] A_NONE   = 12'h340;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        timer;
    logic [31:0] pc;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic        we;
    logic        mret;
    logic [31:0] rdata;
    logic        rvalid;
    logic [31:0] rpc;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    csr_irq_unit dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .timer_irq_i      (timer),
        .pc_i             (pc),
        .csr_addr_i       (addr),
        .csr_wdata_i      (wdata),
        .csr_we_i         (we),
        .mret_i           (mret),
        .csr_rdata_o      (rdata),
        .redirect_valid_o (rvalid),
        .redirect_pc_o    (rpc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic end_cycle();
        @(posedge clk);
        #1;
        we = 1'b0; mret = 1'b0; timer = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a; we = 1'b0;
        #1 v = rdata;
        end_cycle();
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic [31:0] old);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        #1 old = rdata;
        end_cycle();
    endtask

    task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse_timer(input logic [31:0] p);
        @(negedge clk);
        timer = 1'b1; pc = p;
        #1 chk("R6 no redirect while pulse is being latched", {31'b0, rvalid}, 32'h0);
        end_cycle();
    endtask

    task automatic t_reset();
        expect_rd("R1 status reset", A_STATUS, 32'h0);
        expect_rd("R1 enable reset", A_ENABLE, 32'h0);
        expect_rd("R1 tvec reset", A_TVEC, 32'h0000_0100);
        expect_rd("R1 epc reset", A_EPC, 32'h0);
        expect_rd("R1 cause reset", A_CAUSE, 32'h0);
        expect_rd("R1 pending reset", A_PEND, 32'h0);
        chk("R1 redirect low", {31'b0, rvalid}, 32'h0);
    endtask

    task automatic t_readwrite();
        logic [31:0] old;
        wr(A_TVEC, 32'h0000_2003, old);
        chk("R3 old tvec returned", old, 32'h0000_0100);
        expect_rd("R4 tvec low bits zero", A_TVEC, 32'h0000_2000);
        wr(A_STATUS, 32'hFFFF_FFFF, old);
        chk("R3 old status returned", old, 32'h0);
        expect_rd("R4 status mask", A_STATUS, 32'h0000_0088);
        wr(A_STATUS, 32'h0, old);
        chk("R3 status old after write", old, 32'h0000_0088);
        wr(A_ENABLE, 32'hFFFF_FFFF, old);
        expect_rd("R4 enable mask", A_ENABLE, 32'h0000_0080);
        wr(A_EPC, 32'h0000_1237, old);
        expect_rd("R4 epc aligned", A_EPC, 32'h0000_1234);
        wr(A_CAUSE, 32'h0000_0005, old);
        expect_rd("R4 cause full width", A_CAUSE, 32'h0000_0005);
        wr(A_PEND, 32'hFFFF_FFFF, old);
        expect_rd("R4 pending mask", A_PEND, 32'h0000_0080);
        wr(A_PEND, 32'h0, old);
    endtask

    task automatic t_unimpl();
        logic [31:0] old;
        wr(A_NONE, 32'hDEAD_BEEF, old);
        chk("R5 unimplemented old value zero", old, 32'h0);
        expect_rd("R5 unimplemented reads zero", A_NONE, 32'h0);
        expect_rd("R5 status untouched", A_STATUS, 32'h0);
        expect_rd("R5 tvec untouched", A_TVEC, 32'h0000_2000);
        expect_rd("R5 cause untouched", A_CAUSE, 32'h0000_0005);
    endtask

    task automatic t_masked();
        logic [31:0] old;
        // Global enable off, timer enable on.
        wr(A_STATUS, 32'h0, old);
        wr(A_ENABLE, 32'h80, old);
        pulse_timer(32'h300);
        @(negedge clk); #1;
        chk("R6 no redirect with global enable off", {31'b0, rvalid}, 32'h0);
        expect_rd("R2 pending set while masked", A_PEND, 32'h80);
        wr(A_PEND, 32'h0, old);
        // Global enable on, timer enable off.
        wr(A_ENABLE, 32'h0, old);
        wr(A_STATUS, 32'h8, old);
        pulse_timer(32'h300);
        @(negedge clk); #1;
        chk("R6 no redirect with timer enable off", {31'b0, rvalid}, 32'h0);
        expect_rd("R2 pending set with timer enable off", A_PEND, 32'h80);
        wr(A_PEND, 32'h0, old);
    endtask

    task automatic t_take();
        logic [31:0] old;
        wr(A_ENABLE, 32'h80, old);
        wr(A_STATUS, 32'h8, old);
        pulse_timer(32'h400);
        @(negedge clk);
        pc = 32'h0000_0403;
        #1;
        chk("R6 redirect valid on entry", {31'b0, rvalid}, 32'h1);
        chk("R6 redirect to vector", rpc, 32'h0000_2000);
        end_cycle();
        #1 chk("R7 redirect drops after entry", {31'b0, rvalid}, 32'h0);
        expect_rd("R7 epc saved aligned", A_EPC, 32'h0000_0400);
        expect_rd("R7 cause timer code", A_CAUSE, 32'h8000_0007);
        expect_rd("R7 status stacked", A_STATUS, 32'h0000_0080);
        expect_rd("R7 pending cleared", A_PEND, 32'h0);
    endtask

    task automatic t_mret();
        @(negedge clk);
        mret = 1'b1; pc = 32'h0000_2040;
        #1;
        chk("R8 mret redirect valid", {31'b0, rvalid}, 32'h1);
        chk("R8 mret target epc", rpc, 32'h0000_0400);
        end_cycle();
        expect_rd("R8 enable restored, stacked set", A_STATUS, 32'h0000_0088);
    endtask

    task automatic t_irq_vs_mret();
        pulse_timer(32'h480);
        @(negedge clk);
        mret = 1'b1; pc = 32'h0000_0500;
        #1;
        chk("R9 redirect valid", {31'b0, rvalid}, 32'h1);
        chk("R9 interrupt wins target", rpc, 32'h0000_2000);
        end_cycle();
        expect_rd("R9 mret pc saved", A_EPC, 32'h0000_0500);
        expect_rd("R9 status from entry", A_STATUS, 32'h0000_0080);
    endtask

    task automatic t_irq_vs_csr();
        logic [31:0] old;
        wr(A_STATUS, 32'h8, old);
        pulse_timer(32'h580);
        @(negedge clk);
        we = 1'b1; addr = A_CAUSE; wdata = 32'h0000_1234; pc = 32'h0000_0600;
        #1 chk("R10 redirect valid", {31'b0, rvalid}, 32'h1);
        end_cycle();
        expect_rd("R10 csr write dropped", A_CAUSE, 32'h8000_0007);
        expect_rd("R10 epc from entry", A_EPC, 32'h0000_0600);
    endtask

    task automatic t_timer_vs_clear();
        logic [31:0] old;
        wr(A_STATUS, 32'h0, old);
        @(negedge clk);
        timer = 1'b1; we = 1'b1; addr = A_PEND; wdata = 32'h0;
        end_cycle();
        expect_rd("R11 timer beats software clear", A_PEND, 32'h80);
        chk("R11 no redirect while masked", {31'b0, rvalid}, 32'h0);
        wr(A_PEND, 32'h0, old);
        expect_rd("R11 software clear alone works", A_PEND, 32'h0);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; timer = 1'b0; pc = '0; addr = '0;
        wdata = '0; we = 1'b0; mret = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_readwrite();
        t_unimpl();
        t_masked();
        t_take();
        t_mret();
        t_irq_vs_mret();
        t_irq_vs_csr();
        t_timer_vs_clear();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule